// File: doc/BRIEF.md
# Coprocessor State Frame Save and Restore Controller

This block moves the coprocessor's internal state frame between the coprocessor and memory through a 32-bit word interface. A save command writes one of two frames. If the coprocessor has been reset and has not run an operation since, the frame is a single zero word. Otherwise it is a seven-word idle frame. The frame goes either upward from the base address, like a post-increment store, or downward below the base address, like a pre-decrement store. Either way, the block returns the address-register value that the addressing mode leaves behind.

A restore command reads only the header word. A header whose top byte is zero marks an empty frame. The block then reinitialises the coprocessor: it pulses a clear for the control, status and instruction-address registers, writes a not-a-number pattern into every floating-point register in turn, and sets the just-reset flag. Any other header clears the flag. With post-increment, the header's size byte also sets how far the address register moves. The frame body is never read. The sequencer above the block issues one command at a time and reports each arithmetic or move operation on a strobe, which clears the flag.

Top module: `fsr_ctrl`

## Requirements
- R1: While reset is held and right after it is released: busy, done, mem_req, fpr_we, ctl_clr and fmt_err are 0, and just_reset is 1.
- R2: Save with just_reset 0 and cmd_up 1 writes seven words at base, base+4, ..., base+24, in ascending order. The data is 0x1F180000 at base, 0x70000000 at base+24, and zero at the other five addresses. addr_out is base+28.
- R3: Save with just_reset 0 and cmd_up 0 writes seven words in descending order. The data is 0x70000000 at base-4, zero at base-8 through base-24, and 0x1F180000 at base-28. addr_out is base-28.
- R4: Save with just_reset 1 writes one zero word, at base when cmd_up is 1 or at base-4 when cmd_up is 0. addr_out is base+4 or base-4 respectively. just_reset stays 1.
- R5: A restore reads one word at base. If bits 31:24 of that word are zero, the frame is empty: ctl_clr pulses for one cycle alongside the first register write, fpr_we writes indices 0 to NUM_FPR-1 on consecutive cycles with sign 0, exponent all ones and mantissa all ones, and just_reset becomes 1.
- R6: A restore with a non-zero top byte clears just_reset. With cmd_up 1, addr_out is base+4 plus 24, 56 or 180 for size byte (bits 23:16) 0x18, 0x38 or 0xB4. An empty frame with cmd_up 1 gives base+4.
- R7: A restore with cmd_up 0 (plain indirect) returns addr_out equal to base for every header, and fmt_err is 0.
- R8: A non-empty restore with cmd_up 1 and any other size byte returns addr_out equal to base and fmt_err 1 with done. fmt_err is 0 in every other case.
- R9: op_exec while the block is idle clears just_reset from the next cycle onward.
- R10: When op_exec arrives in the same cycle that an empty-frame header is accepted, just_reset ends up 1.
- R11: mem_req stays high, and mem_addr, mem_we and mem_wdata stay stable, until mem_ready is seen. No new word is issued before that.
- R12: cmd_valid is ignored while busy is 1. It starts no transfer and does not change the running command's result.
- R13: done is a one-cycle pulse after the last memory word or register write. addr_out and fmt_err are valid while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start command, taken when idle |
| cmd_restore | input | 1 | 1 restore, 0 save |
| cmd_up | input | 1 | Save: 1 ascending, 0 descending. Restore: 1 post-increment, 0 indirect |
| cmd_addr | input | AW | Address register value at the start |
| op_exec | input | 1 | An arithmetic or move operation executed |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| ctl_clr | output | 1 | Clear control, status and instruction-address registers |
| fpr_we | output | 1 | Floating-point register write |
| fpr_idx | output | IW | Register index |
| fpr_wdata | output | 1+EXP_W+MANT_W | Sign, exponent, mantissa written |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command finished |
| addr_out | output | AW | Updated address register value |
| fmt_err | output | 1 | Unrecognised size byte on restore |
| just_reset | output | 1 | Coprocessor is in its reset state |

## Verification
Two updates to the just-reset flag can land in the same cycle: an operation strobe that clears it, and an empty-frame header that sets it. The bench provokes this collision by raising op_exec in exactly the cycle in which its memory model grants the header read of an empty-frame restore. It then requires the flag to be 1 when done arrives. A second collision pairs a start command with a transfer already in progress. The bench pulses cmd_valid with different operands while the memory holds back mem_ready, then checks that only the original transfers appear and that the original result is returned.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int IDLE_WORDS = 7;
    localparam int WIDX_W     = 3;

    localparam logic [WORD_W-1:0] IDLE_HEAD = 32'h1F18_0000;
    localparam logic [WORD_W-1:0] IDLE_TAIL = 32'h7000_0000;

    localparam logic [7:0] SZ_SHORT = 8'h18;
    localparam logic [7:0] SZ_MID   = 8'h38;
    localparam logic [7:0] SZ_LONG  = 8'hB4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FILL,
        ST_DONE
    } fsr_state_e;

    typedef struct packed {
        logic       is_null;
        logic       known;
        logic [7:0] extra_bytes;
    } fsr_class_t;

    function automatic fsr_class_t decode_header(input logic [WORD_W-1:0] hdr);
        fsr_class_t c;
        c.is_null = (hdr[31:24] == 8'h00);
        c.known   = 1'b1;
        case (hdr[23:16])
            SZ_SHORT: c.extra_bytes = 8'd24;
            SZ_MID:   c.extra_bytes = 8'd56;
            SZ_LONG:  c.extra_bytes = 8'd180;
            default: begin
                c.extra_bytes = 8'd0;
                c.known       = 1'b0;
            end
        endcase
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] save_word(input logic up, input logic empty,
                                                    input logic [WIDX_W-1:0] idx);
        if (empty)
            return '0;
        if (idx == '0)
            return up ? IDLE_HEAD : IDLE_TAIL;
        if (idx == WIDX_W'(IDLE_WORDS - 1))
            return up ? IDLE_TAIL : IDLE_HEAD;
        return '0;
    endfunction

endpackage

// File: rtl/fsr_word_gen.sv
module fsr_word_gen
    import fsr_pkg::*;
(
    input  logic              up,
    input  logic              empty,
    input  logic [WIDX_W-1:0] idx,
    output logic [WORD_W-1:0] word
);
    // Frame word for position idx in issue order, mirrored for descending saves.
    always_comb word = save_word(up, empty, idx);
endmodule

// File: rtl/fsr_hdr_decode.sv
module fsr_hdr_decode
    import fsr_pkg::*;
(
    input  logic [WORD_W-1:0] hdr,
    output fsr_class_t        cls
);
    always_comb cls = decode_header(hdr);
endmodule

// File: rtl/fsr_fill_walk.sv
module fsr_fill_walk #(
    parameter  int NUM_FPR = 8,
    localparam int IW      = (NUM_FPR > 1) ? $clog2(NUM_FPR) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          we,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_FPR - 1);

    logic          active_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == LAST_IDX) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign we   = active_q;
    assign idx  = idx_q;
    assign last = active_q && (idx_q == LAST_IDX);
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter  int AW      = 32,
    parameter  int NUM_FPR = 8,
    parameter  int EXP_W   = 15,
    parameter  int MANT_W  = 64,
    localparam int IW      = (NUM_FPR > 1) ? $clog2(NUM_FPR) : 1,
    localparam int FPR_W   = 1 + EXP_W + MANT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_restore,
    input  logic              cmd_up,
    input  logic [AW-1:0]     cmd_addr,
    input  logic              op_exec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ctl_clr,
    output logic              fpr_we,
    output logic [IW-1:0]     fpr_idx,
    output logic [FPR_W-1:0]  fpr_wdata,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     addr_out,
    output logic              fmt_err,
    output logic              just_reset
);
    localparam logic [AW-1:0]     STEP     = AW'(WORD_BYTES);
    localparam logic [AW-1:0]     SPAN     = AW'(WORD_BYTES * IDLE_WORDS);
    localparam logic [WIDX_W-1:0] IDLE_LST = WIDX_W'(IDLE_WORDS - 1);

    fsr_state_e        state_q;
    logic              restore_q;
    logic              up_q;
    logic              empty_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     result_q;
    logic [WIDX_W-1:0] widx_q;
    logic [WIDX_W-1:0] wlast_q;
    logic              fmt_q;
    logic              jr_q;

    fsr_class_t        cls;
    logic [WORD_W-1:0] save_data;
    logic              hdr_take;
    logic              walk_last;

    fsr_word_gen u_word (
        .up    (up_q),
        .empty (empty_q),
        .idx   (widx_q),
        .word  (save_data)
    );

    fsr_hdr_decode u_hdr (
        .hdr (mem_rdata),
        .cls (cls)
    );

    assign hdr_take = (state_q == ST_XFER) && restore_q && mem_ready;

    fsr_fill_walk #(.NUM_FPR(NUM_FPR)) u_walk (
        .clk   (clk),
        .rst   (rst),
        .start (hdr_take && cls.is_null),
        .we    (fpr_we),
        .idx   (fpr_idx),
        .last  (walk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            restore_q <= 1'b0;
            up_q      <= 1'b0;
            empty_q   <= 1'b0;
            base_q    <= '0;
            addr_q    <= '0;
            result_q  <= '0;
            widx_q    <= '0;
            wlast_q   <= '0;
            fmt_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        restore_q <= cmd_restore;
                        up_q      <= cmd_up;
                        base_q    <= cmd_addr;
                        widx_q    <= '0;
                        fmt_q     <= 1'b0;
                        empty_q   <= jr_q;
                        state_q   <= ST_XFER;
                        if (cmd_restore) begin
                            addr_q  <= cmd_addr;
                            wlast_q <= '0;
                        end else begin
                            addr_q   <= cmd_up ? cmd_addr : cmd_addr - STEP;
                            wlast_q  <= jr_q ? '0 : IDLE_LST;
                            result_q <= cmd_up ? cmd_addr + (jr_q ? STEP : SPAN)
                                               : cmd_addr - (jr_q ? STEP : SPAN);
                        end
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        if (!restore_q) begin
                            if (widx_q == wlast_q) begin
                                state_q <= ST_DONE;
                            end else begin
                                widx_q <= widx_q + 1'b1;
                                addr_q <= up_q ? addr_q + STEP : addr_q - STEP;
                            end
                        end else if (cls.is_null) begin
                            result_q <= up_q ? base_q + STEP : base_q;
                            state_q  <= ST_FILL;
                        end else begin
                            if (!up_q) begin
                                result_q <= base_q;
                            end else if (cls.known) begin
                                result_q <= base_q + STEP + AW'(cls.extra_bytes);
                            end else begin
                                result_q <= base_q;
                                fmt_q    <= 1'b1;
                            end
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_FILL: begin
                    if (walk_last)
                        state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Header acceptance has priority over an operation strobe in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            jr_q <= 1'b1;
        else if (hdr_take)
            jr_q <= cls.is_null;
        else if (op_exec)
            jr_q <= 1'b0;
    end

    assign mem_req    = (state_q == ST_XFER);
    assign mem_we     = !restore_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = restore_q ? '0 : save_data;
    assign ctl_clr    = fpr_we && (fpr_idx == '0);
    assign fpr_wdata  = {1'b0, {EXP_W{1'b1}}, {MANT_W{1'b1}}};
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign addr_out   = result_q;
    assign fmt_err    = done && fmt_q;
    assign just_reset = jr_q;
endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk #(
    parameter  int AW      = 32,
    parameter  int NUM_FPR = 8,
    localparam int IW      = (NUM_FPR > 1) ? $clog2(NUM_FPR) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          op_exec,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready,
    input logic          ctl_clr,
    input logic          fpr_we,
    input logic [IW-1:0] fpr_idx,
    input logic          busy,
    input logic          done,
    input logic          fmt_err,
    input logic          just_reset
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_FPR - 1);

    a_r11_hold_word: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r11_req_in_cmd: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_fill_step: assert property (@(posedge clk) disable iff (rst)
        fpr_we && (fpr_idx != LAST_IDX) |=> fpr_we && (fpr_idx == IW'($past(fpr_idx) + 1'b1)));

    a_r5_clear_first: assert property (@(posedge clk) disable iff (rst)
        ctl_clr |-> fpr_we && (fpr_idx == '0));

    a_r5_fill_busy: assert property (@(posedge clk) disable iff (rst)
        fpr_we |-> busy && !mem_req);

    a_r9_exec_clears: assert property (@(posedge clk) disable iff (rst)
        op_exec && !busy |=> !just_reset);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> done);
endmodule

bind fsr_ctrl fsr_ctrl_chk #(.AW(AW), .NUM_FPR(NUM_FPR)) u_fsr_chk (
    .clk        (clk),
    .rst        (rst),
    .op_exec    (op_exec),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .ctl_clr    (ctl_clr),
    .fpr_we     (fpr_we),
    .fpr_idx    (fpr_idx),
    .busy       (busy),
    .done       (done),
    .fmt_err    (fmt_err),
    .just_reset (just_reset)
);

// File: tb/test_fsr_ctrl.sv
`timescale 1ns/1ps
module test_fsr_ctrl;
    localparam int K_MW = 0, K_MR = 1, K_CTL = 2, K_FPR = 3;
    localparam logic [79:0] FILL_VAL = {1'b0, 15'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF};

    typedef struct {
        int          kind;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0, cmd_restore = 0, cmd_up = 0;
    logic [31:0] cmd_addr = '0;
    logic        op_exec = 0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 0;
    logic [31:0] mem_rdata = '0;
    logic        ctl_clr, fpr_we;
    logic [2:0]  fpr_idx;
    logic [79:0] fpr_wdata;
    logic        busy, done, fmt_err, just_reset;
    logic [31:0] addr_out;

    item_t exp_q[$];
    int    n_chk = 0, n_fail = 0, cyc = 0;
    int    lat = 0, wait_cnt = 0;
    bit    exec_pulse = 0, exec_at_grant = 0, waiting_prev = 0;
    logic [31:0] held_addr = '0;

    fsr_ctrl i_fsr_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_restore(cmd_restore),
        .cmd_up(cmd_up), .cmd_addr(cmd_addr), .op_exec(op_exec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ctl_clr(ctl_clr),
        .fpr_we(fpr_we), .fpr_idx(fpr_idx), .fpr_wdata(fpr_wdata), .busy(busy),
        .done(done), .addr_out(addr_out), .fmt_err(fmt_err), .just_reset(just_reset)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pop_item(input int kind, input string req, output item_t it);
        if (exp_q.size() == 0) begin
            chk(0, {req, " unexpected event"}, 64'(kind), 64'hFFFF);
            it.kind = -1; it.addr = '0; it.data = '0;
        end else begin
            it = exp_q.pop_front();
            chk(it.kind == kind, {req, " event kind"}, 64'(kind), 64'(it.kind));
        end
    endtask

    // Monitor and memory model: grants after lat waits, compares against the queue.
    always @(negedge clk) begin
        item_t it;
        if (rst) begin
            mem_ready = 0; wait_cnt = 0; op_exec = 0; waiting_prev = 0;
        end else begin
            op_exec = 0;
            if (exec_pulse) begin op_exec = 1; exec_pulse = 0; end
            if (ctl_clr) pop_item(K_CTL, "R5 ctl_clr", it);
            if (fpr_we) begin
                pop_item(K_FPR, "R5 fpr write", it);
                chk(fpr_idx == it.addr[2:0], "R5 fpr_idx", 64'(fpr_idx), 64'(it.addr[2:0]));
                chk(fpr_wdata == FILL_VAL, "R5 fpr_wdata", fpr_wdata[79:16], FILL_VAL[79:16]);
            end
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    if (mem_we) pop_item(K_MW, "R2 R3 R4 write", it);
                    else        pop_item(K_MR, "R5 read", it);
                    chk(mem_addr == it.addr, "R2 R3 R4 R5 mem_addr", 64'(mem_addr), 64'(it.addr));
                    if (mem_we)
                        chk(mem_wdata == it.data, "R2 R3 R4 mem_wdata", 64'(mem_wdata), 64'(it.data));
                    else
                        mem_rdata = it.data;
                    mem_ready = 1; wait_cnt = 0; waiting_prev = 0;
                    if (exec_at_grant) begin op_exec = 1; exec_at_grant = 0; end
                end else begin
                    if (waiting_prev)
                        chk(mem_addr == held_addr, "R11 held address", 64'(mem_addr), 64'(held_addr));
                    held_addr = mem_addr; waiting_prev = 1;
                    mem_ready = 0; wait_cnt++;
                end
            end else begin
                mem_ready = 0;
            end
        end
    end

    task automatic push_save(input bit up, input logic [31:0] base, input bit empty);
        if (empty) begin
            exp_q.push_back('{K_MW, up ? base : base - 4, 32'h0});
        end else begin
            for (int k = 0; k < 7; k++) begin
                logic [31:0] a, d;
                a = up ? base + 32'(4 * k) : base - 32'(4 + 4 * k);
                if (k == 0)      d = up ? 32'h1F18_0000 : 32'h7000_0000;
                else if (k == 6) d = up ? 32'h7000_0000 : 32'h1F18_0000;
                else             d = 32'h0;
                exp_q.push_back('{K_MW, a, d});
            end
        end
    endtask

    task automatic push_restore(input logic [31:0] base, input logic [31:0] hdr);
        exp_q.push_back('{K_MR, base, hdr});
        if (hdr[31:24] == 8'h00) begin
            exp_q.push_back('{K_CTL, 32'h0, 32'h0});
            for (int r = 0; r < 8; r++) exp_q.push_back('{K_FPR, 32'(r), 32'h0});
        end
    endtask

    task automatic run_cmd(input bit rs, input bit up, input logic [31:0] base, input bit spurious,
                           input logic [31:0] exp_addr, input bit exp_fmt, input bit exp_jr,
                           input string tag);
        @(negedge clk);
        cmd_valid = 1; cmd_restore = rs; cmd_up = up; cmd_addr = base;
        @(negedge clk);
        cmd_valid = 0;
        if (spurious) begin
            cmd_valid = 1; cmd_restore = ~rs; cmd_up = ~up; cmd_addr = base + 32'h100;
            @(negedge clk);
            cmd_valid = 0;
        end
        while (!done) @(negedge clk);
        chk(addr_out == exp_addr, {tag, " addr_out"}, 64'(addr_out), 64'(exp_addr));
        chk(fmt_err == exp_fmt, {tag, " R8 fmt_err"}, 64'(fmt_err), 64'(exp_fmt));
        chk(just_reset == exp_jr, {tag, " just_reset"}, 64'(just_reset), 64'(exp_jr));
        chk(exp_q.size() == 0, {tag, " events outstanding"}, 64'(exp_q.size()), 64'h0);
        @(negedge clk);
        chk(!done, "R13 done pulse width", 64'(done), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(!busy && !done && !mem_req && !fpr_we && !ctl_clr && !fmt_err, "R1 outputs idle",
            64'({busy, done, mem_req, fpr_we, ctl_clr, fmt_err}), 64'h0);
        chk(just_reset == 1'b1, "R1 just_reset", 64'(just_reset), 64'h1);

        // R9: operation strobe while idle
        exec_pulse = 1;
        repeat (3) @(negedge clk);
        chk(just_reset == 1'b0, "R9 op_exec clears flag", 64'(just_reset), 64'h0);

        // R2: ascending idle frame
        lat = 0; push_save(1, 32'h0000_1000, 0);
        run_cmd(0, 1, 32'h0000_1000, 0, 32'h0000_101C, 0, 0, "R2");
        // R3: descending idle frame with waits (R11)
        lat = 2; push_save(0, 32'h0000_2000, 0);
        run_cmd(0, 0, 32'h0000_2000, 0, 32'h0000_1FE4, 0, 0, "R3 R11");
        // R5 R7: empty frame, indirect
        lat = 1; push_restore(32'h0000_3000, 32'h0000_0000);
        run_cmd(1, 0, 32'h0000_3000, 0, 32'h0000_3000, 0, 1, "R5 R7");
        // R4: empty save both directions
        lat = 0; push_save(1, 32'h0000_4000, 1);
        run_cmd(0, 1, 32'h0000_4000, 0, 32'h0000_4004, 0, 1, "R4 up");
        push_save(0, 32'h0000_5000, 1);
        run_cmd(0, 0, 32'h0000_5000, 0, 32'h0000_4FFC, 0, 1, "R4 down");
        // R6: sized restores
        push_restore(32'h0000_6000, 32'h1F18_0000);
        run_cmd(1, 1, 32'h0000_6000, 0, 32'h0000_601C, 0, 0, "R6 size18");
        lat = 1; push_restore(32'h0000_6100, 32'h1F38_0000);
        run_cmd(1, 1, 32'h0000_6100, 0, 32'h0000_613C, 0, 0, "R6 size38");
        push_restore(32'h0000_6200, 32'h41B4_0000);
        run_cmd(1, 1, 32'h0000_6200, 0, 32'h0000_62B8, 0, 0, "R6 sizeB4");
        // R8: unknown size byte
        push_restore(32'h0000_6300, 32'h1F20_0000);
        run_cmd(1, 1, 32'h0000_6300, 0, 32'h0000_6300, 1, 0, "R8 unknown");
        // R7: indirect with sized header
        push_restore(32'h0000_7000, 32'h1F38_0000);
        run_cmd(1, 0, 32'h0000_7000, 0, 32'h0000_7000, 0, 0, "R7 indirect");
        // R10: op_exec coincides with empty header acceptance
        lat = 0; exec_at_grant = 1; push_restore(32'h0000_8000, 32'h0000_0000);
        run_cmd(1, 1, 32'h0000_8000, 0, 32'h0000_8004, 0, 1, "R10 R5 R6");
        // R12: start command while busy is ignored
        lat = 3; push_save(1, 32'h0000_9000, 1);
        run_cmd(0, 1, 32'h0000_9000, 1, 32'h0000_9004, 0, 1, "R12");
        repeat (6) @(negedge clk);
        chk(!busy && !mem_req, "R12 no extra command", 64'({busy, mem_req}), 64'h0);
        chk(exp_q.size() == 0, "R12 no extra events", 64'(exp_q.size()), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule